// File: doc/BRIEF.md
# Double-Buffered DAC Update Controller

This block is the digital control front end of a 12-bit voltage DAC. Software loads a code into a staging (next) slot. On each DAC clock tick that is allowed to update, the staged code moves into the current-code register. Software can also write the current code directly. The current code is decoded for unsigned or offset-signed operation and goes to the resistor ladder. Updates can be throttled by an external strobe, which is qualified either by its rising edge or by its level.

After every update of the current code, a deglitch timer runs for a programmed number of peripheral clock cycles plus one. While it runs, it forces selected output switches open so that the ladder's settling transient does not reach the pin. The block also produces the power-down, output-enable, disabled-drive and one-LSB-lift controls for the analog section. It raises an "empty" interrupt each time the staged code is consumed, with set, write-one-to-clear and mask logic.

All state is reached through a simple single-cycle register write port with a combinational read path. The DAC tick is a one-cycle enable inside the peripheral clock domain.

Top module: `vdac_update_ctrl`

## Requirements
- R1: After reset, every register reads zero, `dac_code` is 0, `irq` is 0, `ana_pwr_dn` is 1 and `sw_close` is 0.
- R2: The transfer from the next slot to the current code happens only while the CTRL enable bit (bit 15) is 1, and only on a cycle with `dac_tick` high. If a direct write to the current-code address (7) lands in the same cycle, the transfer wins. If a write to the next address (8) lands in the same cycle, the current code takes the old next value and the next slot keeps the written value.
- R3: With strobe gating off (CTRL bit 13 = 0), `strobe_in` is ignored and every tick transfers. With gating on and level qualification selected (CTRL bit 14 = 1), every tick transfers while `strobe_in` is high and none transfers while it is low.
- R4: With gating on and edge qualification selected (CTRL bit 14 = 0), a rising edge of `strobe_in` arms one transfer. The armed state persists until the next tick, which performs the transfer and consumes the arm. A further tick without a new edge does not transfer.
- R5: Every update of the current code opens a deglitch window starting the next cycle and lasting CTRL[5:0]+1 cycles. During the window, switch 1 (`sw_close[1]`) is forced open if CTRL bit 6 is 1, and switch 2 (`sw_close[2]`) is forced open if CTRL bit 7 is 1. Switch 0 is never forced.
- R6: Mode field CTRL[11:10]: 0 passes the code unchanged, and 1 inverts the code MSB (adds 0x800 modulo 4096). The reserved encodings 2 and 3 pass the code unchanged.
- R7: While the enable bit is 0, `ana_pwr_dn` is 1, `sw_close` is 0, `out_hiz` is 1, and `out_drive`, `out_rail_low`, `out_rail_ref` and `lsb_lift` are 0, whatever the other bits hold.
- R8: While enabled, output-enable (CTRL bit 8) = 1 gives `out_drive` = 1. With it 0: if disabled-drive (CTRL bit 12) is 0, `out_hiz` is 1; if it is 1, `out_rail_low` is 1 when range (CTRL bit 9) is 0 and `out_rail_ref` is 1 when range is 1. `lsb_lift` follows the range bit.
- R9: The interrupt request (address 1, bit 0) is set by every transfer and cleared by writing 1 to it. Writing 1 to address 2 bit 0 sets it. When a transfer and a clearing write occur in the same cycle, the request ends up set.
- R10: `irq` and the masked status read at address 4 bit 0 equal the request AND the mask bit (address 3, bit 0).
- R11: Writing 1s to address 5 sets the matching bits of the 3-bit software switch state. Writing 1s to address 6 clears them. Both addresses read back the state. `sw_close[i]` is the state bit, subject to R5 and R7.
- R12: Register addresses: 0 CTRL, 1 request, 2 request set (reads 0), 3 mask, 4 masked status, 5 switch set, 6 switch clear, 7 current code, 8 next code. CTRL[5:0] holds the deglitch count.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Peripheral clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| dac_tick | input | 1 | One-cycle DAC clock tick enable |
| strobe_in | input | 1 | External update throttle strobe |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 4 | Register address |
| reg_wdata | input | 16 | Register write data |
| reg_rdata | output | 16 | Register read data (combinational on reg_addr) |
| dac_code | output | 12 | Decoded code to the ladder |
| lsb_lift | output | 1 | Close ladder bottom switch (adds one LSB) |
| ana_pwr_dn | output | 1 | Analog power-down |
| out_drive | output | 1 | Output amplifier drives the code |
| out_hiz | output | 1 | Output tri-stated |
| out_rail_low | output | 1 | Output forced to the low rail |
| out_rail_ref | output | 1 | Output forced to the reference |
| sw_close | output | 3 | Switch close controls (0 supply, 1 pin, 2 buffer path) |
| irq | output | 1 | Masked empty interrupt |

## Verification
A wrong staging or arm state shows up at `dac_code` on the cycle after the tick that should or should not have transferred. A stale or stuck arm is therefore visible within one tick. A wrong deglitch counter shows as `sw_close[1]` or `sw_close[2]` reopening one cycle early or late relative to the count plus one. A wrong request bit reaches `irq` one cycle after the event that set or cleared it once the mask is on. The enable and drive decode are combinational from the control register, so any error appears on the cycle right after the control write.

// File: rtl/vdac_pkg.sv
package vdac_pkg;

  localparam int ADR_CTRL     = 0;
  localparam int ADR_REQ      = 1;
  localparam int ADR_REQ_SET  = 2;
  localparam int ADR_MASK     = 3;
  localparam int ADR_MASKED   = 4;
  localparam int ADR_SW_SET   = 5;
  localparam int ADR_SW_CLR   = 6;
  localparam int ADR_CUR      = 7;
  localparam int ADR_NXT      = 8;

  typedef enum logic [1:0] {
    MODE_UNSIGNED = 2'd0,
    MODE_SIGNED   = 2'd1,
    MODE_RSV_A    = 2'd2,
    MODE_RSV_B    = 2'd3
  } code_mode_e;

  // Control flags, stored above the deglitch count (LSB first: hold_a).
  typedef struct packed {
    logic       enable;
    logic       strobe_level;
    logic       strobe_gate;
    logic       dis_drive;
    code_mode_e mode;
    logic       range;
    logic       out_en;
    logic       hold_b;
    logic       hold_a;
  } ctrl_flags_t;

  localparam int FLAG_W = $bits(ctrl_flags_t);

endpackage

// File: rtl/vdac_regs.sv
module vdac_regs
  import vdac_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int CODE_W = 12,
  parameter int NUM_SW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  input  logic              hw_empty,
  input  logic [CODE_W-1:0] cur_code,
  input  logic [CODE_W-1:0] nxt_code,
  output ctrl_flags_t       flags,
  output logic [CNT_W-1:0]  glitch_len,
  output logic [NUM_SW-1:0] sw_soft,
  output logic              irq_req,
  output logic              irq_mask,
  output logic              cur_wr,
  output logic              nxt_wr,
  output logic [DATA_W-1:0] reg_rdata
);

  localparam int CTRL_W = CNT_W + FLAG_W;

  logic [CTRL_W-1:0] ctrl_q, ctrl_d;
  logic              req_q, req_d;
  logic              mask_q, mask_d;
  logic [NUM_SW-1:0] sw_q, sw_d;

  logic hit_ctrl, hit_req, hit_set, hit_mask, hit_sws, hit_swc;

  always_comb begin
    hit_ctrl = reg_wr && (reg_addr == ADR_CTRL[ADDR_W-1:0]);
    hit_req  = reg_wr && (reg_addr == ADR_REQ[ADDR_W-1:0]);
    hit_set  = reg_wr && (reg_addr == ADR_REQ_SET[ADDR_W-1:0]);
    hit_mask = reg_wr && (reg_addr == ADR_MASK[ADDR_W-1:0]);
    hit_sws  = reg_wr && (reg_addr == ADR_SW_SET[ADDR_W-1:0]);
    hit_swc  = reg_wr && (reg_addr == ADR_SW_CLR[ADDR_W-1:0]);
    cur_wr   = reg_wr && (reg_addr == ADR_CUR[ADDR_W-1:0]);
    nxt_wr   = reg_wr && (reg_addr == ADR_NXT[ADDR_W-1:0]);
  end

  // Next-state logic
  always_comb begin
    ctrl_d = ctrl_q;
    if (hit_ctrl) ctrl_d = reg_wdata[CTRL_W-1:0];

    mask_d = mask_q;
    if (hit_mask) mask_d = reg_wdata[0];

    // hardware set dominates a software clear in the same cycle
    req_d = hw_empty | (hit_set & reg_wdata[0]) | (req_q & ~(hit_req & reg_wdata[0]));

    sw_d = sw_q;
    if (hit_sws)      sw_d = sw_q | reg_wdata[NUM_SW-1:0];
    else if (hit_swc) sw_d = sw_q & ~reg_wdata[NUM_SW-1:0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      req_q  <= 1'b0;
      mask_q <= 1'b0;
      sw_q   <= '0;
    end else begin
      ctrl_q <= ctrl_d;
      req_q  <= req_d;
      mask_q <= mask_d;
      sw_q   <= sw_d;
    end
  end

  assign flags      = ctrl_flags_t'(ctrl_q[CTRL_W-1:CNT_W]);
  assign glitch_len = ctrl_q[CNT_W-1:0];
  assign sw_soft    = sw_q;
  assign irq_req    = req_q;
  assign irq_mask   = mask_q;

  // Read path
  always_comb begin
    reg_rdata = '0;
    unique case (reg_addr)
      ADR_CTRL[ADDR_W-1:0]:   reg_rdata[CTRL_W-1:0] = ctrl_q;
      ADR_REQ[ADDR_W-1:0]:    reg_rdata[0] = req_q;
      ADR_MASK[ADDR_W-1:0]:   reg_rdata[0] = mask_q;
      ADR_MASKED[ADDR_W-1:0]: reg_rdata[0] = req_q & mask_q;
      ADR_SW_SET[ADDR_W-1:0],
      ADR_SW_CLR[ADDR_W-1:0]: reg_rdata[NUM_SW-1:0] = sw_q;
      ADR_CUR[ADDR_W-1:0]:    reg_rdata[CODE_W-1:0] = cur_code;
      ADR_NXT[ADDR_W-1:0]:    reg_rdata[CODE_W-1:0] = nxt_code;
      default:                reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/vdac_strobe_gate.sv
module vdac_strobe_gate (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic strobe,
  input  logic enable,
  input  logic gate,
  input  logic level,
  output logic xfer,
  output logic armed
);

  logic strobe_q;
  logic armed_q, armed_d;
  logic rise;
  logic edge_mode;
  logic allow;

  always_comb begin
    rise      = strobe & ~strobe_q;
    edge_mode = enable & gate & ~level;
    // an edge arms; the next tick consumes the arm
    armed_d   = edge_mode & (armed_q | rise) & ~tick;
    if (!gate)      allow = 1'b1;
    else if (level) allow = strobe;
    else            allow = armed_q | rise;
    xfer      = enable & tick & allow;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      strobe_q <= 1'b0;
      armed_q  <= 1'b0;
    end else begin
      strobe_q <= strobe;
      armed_q  <= armed_d;
    end
  end

  assign armed = armed_q;

endmodule

// File: rtl/vdac_code_path.sv
module vdac_code_path
  import vdac_pkg::*;
#(
  parameter int CODE_W = 12
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              xfer,
  input  logic              cur_wr,
  input  logic              nxt_wr,
  input  logic [CODE_W-1:0] wcode,
  input  code_mode_e        mode,
  output logic [CODE_W-1:0] cur_code,
  output logic [CODE_W-1:0] nxt_code,
  output logic [CODE_W-1:0] dac_code,
  output logic              upd
);

  localparam logic [CODE_W-1:0] MSB_FLIP = {1'b1, {(CODE_W-1){1'b0}}};

  logic [CODE_W-1:0] cur_q, cur_d, nxt_q, nxt_d;

  always_comb begin
    upd   = xfer | cur_wr;
    cur_d = cur_q;
    if (xfer)        cur_d = nxt_q;
    else if (cur_wr) cur_d = wcode;
    nxt_d = nxt_wr ? wcode : nxt_q;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cur_q <= '0;
      nxt_q <= '0;
    end else begin
      cur_q <= cur_d;
      nxt_q <= nxt_d;
    end
  end

  always_comb begin
    unique case (mode)
      MODE_SIGNED: dac_code = cur_q ^ MSB_FLIP;
      default:     dac_code = cur_q;
    endcase
  end

  assign cur_code = cur_q;
  assign nxt_code = nxt_q;

endmodule

// File: rtl/vdac_deglitch.sv
module vdac_deglitch #(
  parameter int CNT_W = 6
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             trig,
  input  logic [CNT_W-1:0] len,
  output logic             active
);

  logic [CNT_W-1:0] cnt_q, cnt_d;
  logic             act_q, act_d;

  always_comb begin
    cnt_d = cnt_q;
    act_d = act_q;
    if (trig) begin
      cnt_d = len;
      act_d = 1'b1;
    end else if (act_q) begin
      if (cnt_q == '0) act_d = 1'b0;
      else             cnt_d = cnt_q - 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      act_q <= 1'b0;
    end else begin
      cnt_q <= cnt_d;
      act_q <= act_d;
    end
  end

  assign active = act_q;

endmodule

// File: rtl/vdac_update_ctrl.sv
module vdac_update_ctrl
  import vdac_pkg::*;
#(
  parameter int ADDR_W = 4,
  parameter int DATA_W = 16,
  parameter int CNT_W  = 6,
  parameter int CODE_W = 12,
  parameter int NUM_SW = 3
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              dac_tick,
  input  logic              strobe_in,
  input  logic              reg_wr,
  input  logic [ADDR_W-1:0] reg_addr,
  input  logic [DATA_W-1:0] reg_wdata,
  output logic [DATA_W-1:0] reg_rdata,
  output logic [CODE_W-1:0] dac_code,
  output logic              lsb_lift,
  output logic              ana_pwr_dn,
  output logic              out_drive,
  output logic              out_hiz,
  output logic              out_rail_low,
  output logic              out_rail_ref,
  output logic [NUM_SW-1:0] sw_close,
  output logic              irq
);

  // Reset: asserted asynchronously, released on the clock
  logic [1:0] rst_sync_q;
  logic       rst_n_s;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_n_s = rst_sync_q[1];

  ctrl_flags_t       flags;
  logic [CNT_W-1:0]  glitch_len;
  logic [NUM_SW-1:0] sw_soft;
  logic              irq_req, irq_mask;
  logic              cur_wr, nxt_wr;
  logic              xfer, armed, upd, glitch_on;
  logic [CODE_W-1:0] cur_code, nxt_code;

  vdac_regs #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CNT_W(CNT_W),
    .CODE_W(CODE_W), .NUM_SW(NUM_SW)
  ) u_regs (
    .clk       (clk),
    .rst_n     (rst_n_s),
    .reg_wr    (reg_wr),
    .reg_addr  (reg_addr),
    .reg_wdata (reg_wdata),
    .hw_empty  (xfer),
    .cur_code  (cur_code),
    .nxt_code  (nxt_code),
    .flags     (flags),
    .glitch_len(glitch_len),
    .sw_soft   (sw_soft),
    .irq_req   (irq_req),
    .irq_mask  (irq_mask),
    .cur_wr    (cur_wr),
    .nxt_wr    (nxt_wr),
    .reg_rdata (reg_rdata)
  );

  vdac_strobe_gate u_gate (
    .clk    (clk),
    .rst_n  (rst_n_s),
    .tick   (dac_tick),
    .strobe (strobe_in),
    .enable (flags.enable),
    .gate   (flags.strobe_gate),
    .level  (flags.strobe_level),
    .xfer   (xfer),
    .armed  (armed)
  );

  vdac_code_path #(.CODE_W(CODE_W)) u_code (
    .clk     (clk),
    .rst_n   (rst_n_s),
    .xfer    (xfer),
    .cur_wr  (cur_wr),
    .nxt_wr  (nxt_wr),
    .wcode   (reg_wdata[CODE_W-1:0]),
    .mode    (flags.mode),
    .cur_code(cur_code),
    .nxt_code(nxt_code),
    .dac_code(dac_code),
    .upd     (upd)
  );

  vdac_deglitch #(.CNT_W(CNT_W)) u_dg (
    .clk   (clk),
    .rst_n (rst_n_s),
    .trig  (upd),
    .len   (glitch_len),
    .active(glitch_on)
  );

  // Per-switch deglitch hold enables: switch 1 <- hold_a, switch 2 <- hold_b
  logic [NUM_SW-1:0] hold_vec;
  always_comb begin
    hold_vec = '0;
    if (NUM_SW > 1) hold_vec[1] = flags.hold_a;
    if (NUM_SW > 2) hold_vec[2] = flags.hold_b;
  end

  for (genvar i = 0; i < NUM_SW; i++) begin : g_sw
    assign sw_close[i] = flags.enable & sw_soft[i] & ~(glitch_on & hold_vec[i]);
  end

  // Output drive decode
  always_comb begin
    ana_pwr_dn   = ~flags.enable;
    lsb_lift     = flags.enable & flags.range;
    out_drive    = flags.enable & flags.out_en;
    out_hiz      = ~flags.enable | (~flags.out_en & ~flags.dis_drive);
    out_rail_low = flags.enable & ~flags.out_en & flags.dis_drive & ~flags.range;
    out_rail_ref = flags.enable & ~flags.out_en & flags.dis_drive &  flags.range;
  end

  assign irq = irq_req & irq_mask;

endmodule

// File: rtl/vdac_update_ctrl_chk.sv
module vdac_update_ctrl_chk
  import vdac_pkg::*;
#(
  parameter int CODE_W = 12,
  parameter int NUM_SW = 3
) (
  input logic              clk,
  input logic              rst_n_s,
  input logic              dac_tick,
  input logic              strobe_in,
  input ctrl_flags_t       flags,
  input logic              xfer,
  input logic              upd,
  input logic              glitch_on,
  input logic              irq_req,
  input logic              reg_set_hit,
  input logic [CODE_W-1:0] cur_code,
  input logic [CODE_W-1:0] nxt_code,
  input logic              ana_pwr_dn,
  input logic [NUM_SW-1:0] sw_close
);

  // R2
  xfer_moves_code_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer |=> (cur_code == $past(nxt_code)));

  // R2
  no_xfer_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    !flags.enable |-> !xfer);

  // R3
  gate_off_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dac_tick && flags.enable && !flags.strobe_gate) |-> xfer);

  // R3
  level_xfer_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    (dac_tick && flags.enable && flags.strobe_gate && flags.strobe_level) |-> (xfer == strobe_in));

  // R5
  glitch_start_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    upd |=> glitch_on);

  // R7
  off_open_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    ana_pwr_dn |-> (sw_close == '0));

  // R9
  empty_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    xfer |=> irq_req);

  // R9
  sw_set_irq_chk: assert property (@(posedge clk) disable iff (!rst_n_s)
    reg_set_hit |=> irq_req);

endmodule

bind vdac_update_ctrl vdac_update_ctrl_chk #(.CODE_W(CODE_W), .NUM_SW(NUM_SW)) u_chk (
  .clk        (clk),
  .rst_n_s    (rst_n_s),
  .dac_tick   (dac_tick),
  .strobe_in  (strobe_in),
  .flags      (flags),
  .xfer       (xfer),
  .upd        (upd),
  .glitch_on  (glitch_on),
  .irq_req    (irq_req),
  .reg_set_hit(reg_wr && (reg_addr == vdac_pkg::ADR_REQ_SET[ADDR_W-1:0]) && reg_wdata[0]),
  .cur_code   (cur_code),
  .nxt_code   (nxt_code),
  .ana_pwr_dn (ana_pwr_dn),
  .sw_close   (sw_close)
);

// File: tb/sim_vdac_update_ctrl.sv
`timescale 1ns/1ps
module sim_vdac_update_ctrl;

  localparam int B_HOLDA = 1 << 6;
  localparam int B_HOLDB = 1 << 7;
  localparam int B_OUTEN = 1 << 8;
  localparam int B_RANGE = 1 << 9;
  localparam int M_SHIFT = 10;
  localparam int B_DIS   = 1 << 12;
  localparam int B_GATE  = 1 << 13;
  localparam int B_LEVEL = 1 << 14;
  localparam int B_EN    = 1 << 15;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        dac_tick, strobe_in, reg_wr;
  logic [3:0]  reg_addr;
  logic [15:0] reg_wdata, reg_rdata;
  logic [11:0] dac_code;
  logic        lsb_lift, ana_pwr_dn, out_drive, out_hiz, out_rail_low, out_rail_ref, irq;
  logic [2:0]  sw_close;

  int checks = 0;
  int failures = 0;

  always #2.5 clk = ~clk;

  vdac_update_ctrl u0 (
    .clk(clk), .rst_n(rst_n), .dac_tick(dac_tick), .strobe_in(strobe_in),
    .reg_wr(reg_wr), .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
    .dac_code(dac_code), .lsb_lift(lsb_lift), .ana_pwr_dn(ana_pwr_dn),
    .out_drive(out_drive), .out_hiz(out_hiz), .out_rail_low(out_rail_low),
    .out_rail_ref(out_rail_ref), .sw_close(sw_close), .irq(irq)
  );

  // {mode[1:0], code[11:0], expected[11:0]} for R6
  localparam logic [25:0] VEC [7] = '{
    {2'd0, 12'h000, 12'h000},
    {2'd0, 12'hABC, 12'hABC},
    {2'd1, 12'h800, 12'h000},
    {2'd1, 12'h7FF, 12'hFFF},
    {2'd1, 12'h000, 12'h800},
    {2'd2, 12'h123, 12'h123},
    {2'd3, 12'hFFF, 12'hFFF}
  };

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      failures++;
      $display("FAIL %s actual=0x%0h expected=0x%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input int a, input int d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 4'(a); reg_wdata = 16'(d);
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int a, output int d);
    @(negedge clk);
    reg_addr = 4'(a);
    #1 d = int'(reg_rdata);
  endtask

  task automatic tick();
    @(negedge clk);
    dac_tick = 1'b1;
    @(negedge clk);
    dac_tick = 1'b0;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    failures++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    int v;
    rst_n = 1'b0; dac_tick = 0; strobe_in = 0; reg_wr = 0; reg_addr = 0; reg_wdata = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);

    // R1 reset state
    rd(0, v);  chk("R1 ctrl", v, 0);
    rd(7, v);  chk("R1 cur", v, 0);
    rd(8, v);  chk("R1 nxt", v, 0);
    rd(1, v);  chk("R1 req", v, 0);
    chk("R1 dac_code", dac_code, 0);
    chk("R1 irq", irq, 0);
    chk("R1 pwr_dn", ana_pwr_dn, 1);
    chk("R1 sw", sw_close, 0);

    // R6 decode table
    for (int i = 0; i < 7; i++) begin
      wr(0, B_EN | (int'(VEC[i][25:24]) << M_SHIFT));
      wr(7, int'(VEC[i][23:12]));
      chk("R6 decode", dac_code, int'(VEC[i][11:0]));
    end

    // R12 ctrl readback
    wr(0, B_EN | 6'h2A);
    rd(0, v); chk("R12 ctrl readback", v, B_EN | 6'h2A);
    rd(2, v); chk("R12 set reads 0", v, 0);

    // R11 switch set/clear
    wr(5, 3'b101);
    wr(6, 3'b001);
    rd(6, v); chk("R11 sw state", v, 3'b100);
    chk("R11 sw_close", sw_close, 3'b100);
    wr(5, 3'b111);

    // R5 deglitch: count 3, hold switch 1 only
    wr(0, B_EN | B_HOLDA | 3);
    wr(7, 12'h100);
    for (int i = 0; i < 4; i++) begin
      chk("R5 window open", sw_close, 3'b101);
      @(negedge clk);
    end
    chk("R5 window closed", sw_close, 3'b111);

    // R5 count 0, hold switch 2 only
    wr(0, B_EN | B_HOLDB);
    wr(7, 12'h101);
    chk("R5 hold_b open", sw_close, 3'b011);
    @(negedge clk);
    chk("R5 hold_b closed", sw_close, 3'b111);

    // R3 gate off, strobe ignored
    wr(0, B_EN);
    wr(8, 12'h5A5);
    tick();
    chk("R3 gate off xfer", dac_code, 12'h5A5);

    // R2 disabled: no transfer
    wr(0, 0);
    wr(8, 12'h111);
    tick();
    chk("R7 pwr_dn", ana_pwr_dn, 1);
    chk("R7 sw open", sw_close, 0);
    chk("R7 hiz", out_hiz, 1);
    rd(7, v); chk("R2 no xfer when off", v, 12'h5A5);

    // R2 same-cycle cur write vs transfer
    wr(0, B_EN);
    @(negedge clk);
    dac_tick = 1; reg_wr = 1; reg_addr = 7; reg_wdata = 16'h0777;
    @(negedge clk);
    dac_tick = 0; reg_wr = 0;
    chk("R2 xfer beats cur write", dac_code, 12'h111);
    @(negedge clk);
    dac_tick = 1; reg_wr = 1; reg_addr = 8; reg_wdata = 16'h0222;
    @(negedge clk);
    dac_tick = 0; reg_wr = 0;
    chk("R2 cur takes old nxt", dac_code, 12'h111);
    rd(8, v); chk("R2 nxt keeps write", v, 12'h222);

    // R4 edge mode
    wr(0, B_EN | B_GATE);
    wr(8, 12'h321);
    tick();
    chk("R4 no edge no xfer", dac_code, 12'h111);
    @(negedge clk); strobe_in = 1;
    @(negedge clk); strobe_in = 0;
    repeat (3) @(negedge clk);
    chk("R4 armed waits tick", dac_code, 12'h111);
    tick();
    chk("R4 edge xfer", dac_code, 12'h321);
    wr(8, 12'h654);
    tick();
    chk("R4 single xfer per edge", dac_code, 12'h321);

    // R3 level mode
    wr(0, B_EN | B_GATE | B_LEVEL);
    strobe_in = 1;
    wr(8, 12'h0AA); tick();
    chk("R3 level xfer 1", dac_code, 12'h0AA);
    wr(8, 12'h0BB); tick();
    chk("R3 level xfer 2", dac_code, 12'h0BB);
    strobe_in = 0;
    wr(8, 12'h0CC); tick();
    chk("R3 level low blocks", dac_code, 12'h0BB);

    // R9/R10 interrupt
    wr(0, B_EN);
    wr(1, 1);
    rd(1, v); chk("R9 w1c", v, 0);
    tick();
    rd(1, v); chk("R9 set by xfer", v, 1);
    chk("R10 masked off", irq, 0);
    wr(3, 1);
    chk("R10 irq on", irq, 1);
    rd(4, v); chk("R10 masked read", v, 1);
    wr(1, 1);
    chk("R10 irq cleared", irq, 0);
    wr(2, 1);
    chk("R9 set register", irq, 1);
    wr(1, 1);
    @(negedge clk);
    dac_tick = 1; reg_wr = 1; reg_addr = 1; reg_wdata = 16'h0001;
    @(negedge clk);
    dac_tick = 0; reg_wr = 0;
    rd(1, v); chk("R9 hw set wins", v, 1);

    // R8 drive selection
    wr(0, B_EN);
    chk("R8 hiz", out_hiz, 1);
    chk("R8 no drive", out_drive, 0);
    wr(0, B_EN | B_DIS);
    chk("R8 rail low", out_rail_low, 1);
    chk("R8 no ref", out_rail_ref, 0);
    wr(0, B_EN | B_DIS | B_RANGE);
    chk("R8 rail ref", out_rail_ref, 1);
    chk("R8 lift", lsb_lift, 1);
    chk("R8 not hiz", out_hiz, 0);
    wr(0, B_EN | B_OUTEN);
    chk("R8 drive", out_drive, 1);
    chk("R8 drive not hiz", out_hiz, 0);
    wr(0, B_DIS | B_RANGE | B_OUTEN);
    chk("R7 off overrides", {out_drive, out_rail_ref, lsb_lift, ana_pwr_dn}, 4'b0001);

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule